// File: doc/BRIEF.md
# I2C Word/Byte FIFO Pair

This block sits between a 32-bit register bus and the byte-serial engine of an I2C controller. Software writes whole words into a transmit queue, and the block hands them to the engine one byte at a time, least significant byte first. In the other direction, bytes arriving from the engine are gathered into words and queued for software to read. When a packet ends on a byte that does not complete a word, the partial word is queued with its unused upper bytes cleared.

Software sees a status word with the free transmit slots and the filled receive words. Each direction has a service request output whose threshold comes from a control field. Each queue has a flush bit that clears itself. A transmit word can be tagged as the packet's tail, with a byte count of 1 to 4. The engine then gets only those bytes, and the final one is marked.

Top module: `i2c_word_fifo_pair`

## Requirements
- R1: A word written at address 0 leaves on `tx_byte` as four bytes in little-endian order: bits 7:0 first, bits 31:24 last. `tx_byte_last` stays low for all four.
- R2: A word written at address 1 is a tail word. Its byte count is control bits 9:8, where 0 means 4. Only that many low-order bytes are sent, and `tx_byte_last` is high with the final one. After that, no further byte is valid.
- R3: A transmit write while 8 words are queued is discarded, and status bit 8 (overflow) becomes 1.
- R4: Four received bytes form one receive word, with the first byte in bits 7:0. Reading address 2 returns the word and removes it.
- R5: A byte received with `rx_byte_last` high closes the word at once. A partial word has its unfilled upper bytes set to zero.
- R6: Reading address 2 while the receive queue is empty returns 0 and sets status bit 9 (underflow).
- R7: In the status word at address 4, bits 7:4 hold the free transmit slots and bits 3:0 hold the filled receive words. Neither field exceeds 8. After reset the status word is 0x080.
- R8: Writing control address 3 with bit 1 set flushes the transmit side, and bit 0 flushes the receive side. A flush bit reads back as 1 on the following cycle and as 0 once the flush is done. The flush empties the queue, drops any partly sent or partly gathered word, and clears that side's error flag.
- R9: `tx_req` is high when the free slots are at least control bits 7:5 plus one. `rx_req` is high when the filled words are at least control bits 4:2 plus one.
- R10: After reset the control register reads 0, `tx_req` is 1, `rx_req` is 0, and no transmit byte is valid.
- R11: A valid transmit byte that is not accepted stays the same until it is accepted. `rx_byte_ready` is low while 8 receive words are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 2) |
| reg_addr | input | 3 | Register address: 0 TX word, 1 TX tail word, 2 RX word, 3 control, 4 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| tx_byte_valid | output | 1 | A transmit byte is offered |
| tx_byte | output | 8 | Offered transmit byte |
| tx_byte_last | output | 1 | Offered byte ends the packet |
| tx_byte_ready | input | 1 | Engine takes the offered byte |
| rx_byte_valid | input | 1 | Engine offers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_byte_last | input | 1 | Received byte ends the packet |
| rx_byte_ready | output | 1 | Block can take a received byte |
| tx_req | output | 1 | Transmit space at or above the trigger |
| rx_req | output | 1 | Receive fill at or above the trigger |

## Verification
A wrong byte index in the unpacker appears on `tx_byte` on the very next accepted byte, as a byte out of order or a missing `tx_byte_last`. A packer fault appears in the first word read back after a packet: bytes shift position, or upper bytes are not zero. Count or pointer corruption appears in the status fields one cycle after the push or pop that caused it, and it pushes `tx_req` and `rx_req` off their thresholds. A flush that does not complete leaves its control bit reading 1 two cycles after the write.

// File: rtl/i2cfp_pkg.sv
package i2cfp_pkg;
  localparam logic [2:0] A_TX_WORD = 3'd0;
  localparam logic [2:0] A_TX_TAIL = 3'd1;
  localparam logic [2:0] A_RX_WORD = 3'd2;
  localparam logic [2:0] A_CTRL    = 3'd3;
  localparam logic [2:0] A_STATUS  = 3'd4;

  typedef struct packed {
    logic        tail;
    logic [1:0]  nbytes;  // 0 encodes 4
    logic [31:0] word;
  } tx_entry_t;
endpackage

// File: rtl/i2cfp_sfifo.sv
module i2cfp_sfifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/i2cfp_tx_unpack.sv
module i2cfp_tx_unpack
  import i2cfp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  tx_entry_t head,
  input  logic      empty,
  input  logic      ready,
  output logic      valid,
  output logic [7:0] data,
  output logic      last,
  output logic      pop
);
  logic [1:0] idx_q, idx_d;
  logic       end_of_word, take;

  assign valid       = !empty;
  assign data        = head.word[8*idx_q +: 8];
  assign end_of_word = (idx_q == head.nbytes - 2'd1);
  assign last        = valid && head.tail && end_of_word;
  assign take        = valid && ready;
  assign pop         = take && end_of_word;

  always_comb begin
    idx_d = idx_q;
    if (clr)       idx_d = '0;
    else if (take) idx_d = end_of_word ? 2'd0 : idx_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/i2cfp_rx_pack.sv
module i2cfp_rx_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  input  logic        byte_last,
  input  logic        fifo_full,
  output logic        ready,
  output logic        push,
  output logic [31:0] word
);
  logic [31:0] acc_q, acc_d;
  logic [1:0]  bidx_q, bidx_d;
  logic        take;

  assign ready = !fifo_full;
  assign take  = byte_valid && ready && !clr;
  assign word  = acc_q | (32'(byte_in) << (8 * bidx_q));
  assign push  = take && (bidx_q == 2'd3 || byte_last);

  always_comb begin
    acc_d  = acc_q;
    bidx_d = bidx_q;
    if (clr || push) begin
      acc_d  = '0;
      bidx_d = '0;
    end else if (take) begin
      acc_d  = word;
      bidx_d = bidx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      bidx_q <= '0;
    end else begin
      acc_q  <= acc_d;
      bidx_q <= bidx_d;
    end
  end
endmodule

// File: rtl/i2c_word_fifo_pair.sv
module i2c_word_fifo_pair
  import i2cfp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_byte_valid,
  output logic [7:0]  tx_byte,
  output logic        tx_byte_last,
  input  logic        tx_byte_ready,
  input  logic        rx_byte_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_byte_last,
  output logic        rx_byte_ready,
  output logic        tx_req,
  output logic        rx_req
);
  localparam int CW = $clog2(DEPTH+1);

  // control and flags
  logic [2:0] tx_trig_q, rx_trig_q, tx_trig_d, rx_trig_d;
  logic [1:0] tail_len_q, tail_len_d;
  logic       tx_flush_q, rx_flush_q, tx_flush_d, rx_flush_d;
  logic       tx_ovf_q, rx_udf_q, tx_ovf_d, rx_udf_d;

  tx_entry_t     tx_in, tx_head;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_wr, tx_pop, rx_push, rx_rd;
  logic [31:0]   rx_word_in, rx_head;
  logic [3:0]    tx_free4, rx_fill4;

  assign tx_wr = reg_wr && (reg_addr == A_TX_WORD || reg_addr == A_TX_TAIL);
  assign rx_rd = reg_rd && (reg_addr == A_RX_WORD);

  assign tx_in.tail   = (reg_addr == A_TX_TAIL);
  assign tx_in.nbytes = (reg_addr == A_TX_TAIL) ? tail_len_q : 2'd0;
  assign tx_in.word   = reg_wdata;

  i2cfp_sfifo #(.W($bits(tx_entry_t)), .DEPTH(DEPTH)) u_tx_fifo (
    .clk, .rst_n, .clr(tx_flush_q), .push(tx_wr), .pop(tx_pop),
    .din(tx_in), .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  i2cfp_tx_unpack u_unpack (
    .clk, .rst_n, .clr(tx_flush_q), .head(tx_head), .empty(tx_empty),
    .ready(tx_byte_ready), .valid(tx_byte_valid), .data(tx_byte),
    .last(tx_byte_last), .pop(tx_pop)
  );

  i2cfp_rx_pack u_pack (
    .clk, .rst_n, .clr(rx_flush_q), .byte_valid(rx_byte_valid), .byte_in(rx_byte),
    .byte_last(rx_byte_last), .fifo_full(rx_full), .ready(rx_byte_ready),
    .push(rx_push), .word(rx_word_in)
  );

  i2cfp_sfifo #(.W(32), .DEPTH(DEPTH)) u_rx_fifo (
    .clk, .rst_n, .clr(rx_flush_q), .push(rx_push), .pop(rx_rd),
    .din(rx_word_in), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign tx_free4 = 4'(DEPTH) - 4'(tx_cnt);
  assign rx_fill4 = 4'(rx_cnt);
  assign tx_req   = ({1'b0, tx_free4} >= ({2'b0, tx_trig_q} + 5'd1));
  assign rx_req   = ({1'b0, rx_fill4} >= ({2'b0, rx_trig_q} + 5'd1));

  always_comb begin
    tx_trig_d  = tx_trig_q;
    rx_trig_d  = rx_trig_q;
    tail_len_d = tail_len_q;
    tx_flush_d = 1'b0;
    rx_flush_d = 1'b0;
    tx_ovf_d   = tx_flush_q ? 1'b0 : tx_ovf_q;
    rx_udf_d   = rx_flush_q ? 1'b0 : rx_udf_q;
    if (reg_wr && reg_addr == A_CTRL) begin
      tx_trig_d  = reg_wdata[7:5];
      rx_trig_d  = reg_wdata[4:2];
      tail_len_d = reg_wdata[9:8];
      tx_flush_d = reg_wdata[1];
      rx_flush_d = reg_wdata[0];
    end
    if (tx_wr && tx_full && !tx_flush_q) tx_ovf_d = 1'b1;
    if (rx_rd && rx_empty && !rx_flush_q) rx_udf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_trig_q  <= '0;
      rx_trig_q  <= '0;
      tail_len_q <= '0;
      tx_flush_q <= 1'b0;
      rx_flush_q <= 1'b0;
      tx_ovf_q   <= 1'b0;
      rx_udf_q   <= 1'b0;
    end else begin
      tx_trig_q  <= tx_trig_d;
      rx_trig_q  <= rx_trig_d;
      tail_len_q <= tail_len_d;
      tx_flush_q <= tx_flush_d;
      rx_flush_q <= rx_flush_d;
      tx_ovf_q   <= tx_ovf_d;
      rx_udf_q   <= rx_udf_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_RX_WORD: reg_rdata = rx_empty ? 32'd0 : rx_head;
      A_CTRL:    reg_rdata = {22'd0, tail_len_q, tx_trig_q, rx_trig_q, tx_flush_q, rx_flush_q};
      A_STATUS:  reg_rdata = {22'd0, rx_udf_q, tx_ovf_q, tx_free4, rx_fill4};
      default:   reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/i2c_word_fifo_pair_chk.sv
module i2c_word_fifo_pair_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          tx_byte_valid,
  input logic [7:0]    tx_byte,
  input logic          tx_byte_ready,
  input logic          rx_byte_ready,
  input logic          tx_flush_q,
  input logic          tx_ovf_q,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd1) && tx_cnt == CW'(DEPTH) && !tx_flush_q)
      |=> tx_ovf_q);

  p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd2 && rx_cnt == '0) |-> reg_rdata == 32'd0);

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  p_flush_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush_q && !(reg_wr && reg_addr == 3'd3 && reg_wdata[1]))
      |=> !tx_flush_q && tx_cnt == '0);

  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_byte_valid && !tx_byte_ready && !tx_flush_q)
      |=> tx_byte_valid && $stable(tx_byte));

  p_rx_full_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CW'(DEPTH)) |-> !rx_byte_ready);
endmodule

bind i2c_word_fifo_pair i2c_word_fifo_pair_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_byte_valid(tx_byte_valid),
  .tx_byte(tx_byte), .tx_byte_ready(tx_byte_ready), .rx_byte_ready(rx_byte_ready),
  .tx_flush_q(tx_flush_q), .tx_ovf_q(tx_ovf_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/i2c_word_fifo_pair_bench.sv
module i2c_word_fifo_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        tx_byte_valid, tx_byte_last, tx_byte_ready;
  logic [7:0]  tx_byte;
  logic        rx_byte_valid, rx_byte_last, rx_byte_ready;
  logic [7:0]  rx_byte;
  logic        tx_req, rx_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  i2c_word_fifo_pair u_i2c_word_fifo_pair (.*);

  // {length code (0 = 4 bytes), word}
  localparam logic [33:0] VEC [5] = '{
    {2'd0, 32'h44332211},
    {2'd1, 32'hDEADBE5A},
    {2'd2, 32'h0BADF00D},
    {2'd3, 32'hC0FFEE77},
    {2'd0, 32'h80402010}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic pull_byte(output logic v, output logic [7:0] b, output logic l);
    @(negedge clk);
    tx_byte_ready = 1'b1;
    #1 v = tx_byte_valid; b = tx_byte; l = tx_byte_last;
    @(posedge clk); #1;
    tx_byte_ready = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic l);
    @(negedge clk);
    rx_byte_valid = 1'b1; rx_byte = b; rx_byte_last = l;
    @(posedge clk); #1;
    rx_byte_valid = 1'b0; rx_byte_last = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic v, l;
    logic [7:0] b;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    tx_byte_ready = 0; rx_byte_valid = 0; rx_byte = 0; rx_byte_last = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R10 / R7 reset state
    bus_read(3'd4, rd); check(rd == 32'h080, "R7 reset status", rd, 32'h080);
    bus_read(3'd3, rd); check(rd == 32'h0, "R10 reset control", rd, 32'h0);
    #1;
    check(tx_req == 1'b1 && rx_req == 1'b0, "R10 reset requests", {tx_req, rx_req}, 2'b10);
    check(tx_byte_valid == 1'b0, "R10 no tx byte", tx_byte_valid, 0);

    // table walk: TX unpack (R1, R2) then RX repack (R4, R5)
    foreach (VEC[k]) begin
      logic [1:0]  lc = VEC[k][33:32];
      logic [31:0] w  = VEC[k][31:0];
      int          n  = (lc == 0) ? 4 : int'(lc);
      logic [31:0] mask = (n == 4) ? 32'hFFFFFFFF : ((32'd1 << (8*n)) - 1);
      bus_write(3'd3, {22'd0, lc, 8'd0});
      bus_write(3'd1, w);
      for (int i = 0; i < n; i++) begin
        pull_byte(v, b, l);
        check(v && b == w[8*i +: 8], "R1 tx byte order", {v, b}, {1'b1, w[8*i +: 8]});
        check(l == (i == n-1), "R2 tx last flag", l, (i == n-1));
      end
      #1 check(tx_byte_valid == 1'b0, "R2 no extra tx byte", tx_byte_valid, 0);
      for (int i = 0; i < n; i++) send_byte(w[8*i +: 8], i == n-1);
      bus_read(3'd2, rd);
      check(rd == (w & mask), (n == 4) ? "R4 rx packed word" : "R5 rx partial word", rd, w & mask);
    end
    bus_write(3'd3, 32'h0);

    // R1 plain word path without tail marking
    bus_write(3'd0, 32'hA1B2C3D4);
    for (int i = 0; i < 4; i++) begin
      pull_byte(v, b, l);
      check(v && !l && b == 8'(32'hA1B2C3D4 >> (8*i)), "R1 plain word bytes", {v, l, b}, {2'b10, 8'(32'hA1B2C3D4 >> (8*i))});
    end

    // R3 overflow, R11 hold
    for (int i = 0; i < 9; i++) bus_write(3'd0, 32'h100 + i);
    bus_read(3'd4, rd);
    check(rd[8] == 1'b1 && rd[7:4] == 4'd0, "R3 overflow flag and full", rd, 32'h100);
    @(negedge clk); b = tx_byte;
    @(negedge clk);
    check(tx_byte_valid && tx_byte == b && b == 8'h00, "R11 tx byte held", tx_byte, b);
    pull_byte(v, b, l);
    // R8 tx flush
    bus_write(3'd3, 32'h2);
    bus_read(3'd3, rd); check(rd[1] == 1'b1, "R8 flush bit pending", rd, 32'h2);
    bus_read(3'd3, rd); check(rd[1] == 1'b0, "R8 flush bit cleared", rd, 32'h0);
    bus_read(3'd4, rd); check(rd == 32'h080, "R8 tx emptied and flag cleared", rd, 32'h080);
    #1 check(tx_byte_valid == 1'b0, "R8 partial tx word dropped", tx_byte_valid, 0);

    // R6 underflow
    bus_read(3'd2, rd); check(rd == 32'h0, "R6 empty read zero", rd, 0);
    bus_read(3'd4, rd); check(rd[9] == 1'b1, "R6 underflow flag", rd, 32'h280);

    // R9 triggers: tx trig 7, rx trig 1
    bus_write(3'd3, 32'hE4);
    #1 check(tx_req == 1'b1, "R9 tx_req at 8 free", tx_req, 1);
    bus_write(3'd0, 32'h5);
    #1 check(tx_req == 1'b0, "R9 tx_req at 7 free", tx_req, 0);
    for (int i = 0; i < 4; i++) send_byte(8'(i), 1'b0);
    #1 check(rx_req == 1'b0, "R9 rx_req at 1 word", rx_req, 0);
    for (int i = 0; i < 4; i++) send_byte(8'(i), 1'b0);
    #1 check(rx_req == 1'b1, "R9 rx_req at 2 words", rx_req, 1);
    bus_write(3'd3, 32'h3);
    repeat (2) @(posedge clk);
    bus_read(3'd4, rd); check(rd == 32'h080, "R8 both flushed", rd, 32'h080);

    // R11 rx full stall, R7 fill count
    for (int i = 0; i < 32; i++) send_byte(8'(i), 1'b0);
    #1 check(rx_byte_ready == 1'b0, "R11 rx ready low when full", rx_byte_ready, 0);
    bus_read(3'd4, rd); check(rd[3:0] == 4'd8, "R7 rx fill 8", rd, 32'h088);
    bus_read(3'd2, rd); check(rd == 32'h03020100, "R4 first packed word", rd, 32'h03020100);

    // R8 flush drops partial packer word
    bus_write(3'd3, 32'h1);
    repeat (2) @(posedge clk);
    send_byte(8'h11, 1'b0); send_byte(8'h22, 1'b0);
    bus_write(3'd3, 32'h1);
    repeat (2) @(posedge clk);
    send_byte(8'hAA, 1'b0); send_byte(8'hBB, 1'b0);
    send_byte(8'hCC, 1'b0); send_byte(8'hDD, 1'b0);
    bus_read(3'd2, rd); check(rd == 32'hDDCCBBAA, "R8 packer restarted", rd, 32'hDDCCBBAA);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule